// File: doc/BRIEF.md
# Debug Event and Halt Controller

This block sits beside a CPU pipeline and decides when the core must stop for a debugger. It watches two software-breakpoint decode strobes and compares the program-fetch and data-access buses against one watch address per space. When any of these fires while the core is running, it raises a halt request and records why the core stopped. A host run command resumes execution on the next clock and wipes the recorded reason.

Two stopping modes exist. In stop mode every event halts at once. In real-time mode an event that arrives while a critical interrupt is being serviced is held back and taken on the first cycle the interrupt input falls, with the cause that was first seen. A free-running 32-bit cycle counter measures code between breakpoints: it advances only while the core runs. A small arbiter lets a debug host borrow the memory buses, but only in cycles the pipeline marks idle; a request that never finds an idle cycle is abandoned after a programmable number of cycles and flagged.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A pulse on `swbp_a_i` while running makes `halt_o` 1 and `cause_o` 1 after the next rising clock edge; a pulse on `swbp_b_i` does the same with `cause_o` 2.
- R2: A valid program fetch (`pf_vld_i` 1) whose address equals `pw_addr_i` while `pw_en_i` is 1 halts the core with `cause_o` 3 after the next edge.
- R3: A valid data access (`da_vld_i` 1) whose address equals `dw_addr_i` while `dw_en_i` is 1 halts the core with `cause_o` 4 after the next edge.
- R4: When several sources fire in the same cycle, the recorded cause follows the order 1, 2, 3, 4 (lowest code wins).
- R5: A watch with its enable at 0, an address that differs, or a bus whose valid is 0 produces no halt.
- R6: While halted, new events change neither `halt_o` nor `cause_o`.
- R7: `run_cmd_i` high while halted makes `halt_o` 0 and `cause_o` 0 after the next edge.
- R8: With `rt_mode_i` 1 and `crit_irq_i` 1, no halt is raised; the held event halts the core, with its original cause, on the edge after `crit_irq_i` falls. With `rt_mode_i` 0 the interrupt input has no effect.
- R9: `cycle_cnt_o` rises by 1 on each edge while running, keeps its value while halted, and reads 0 after an edge at which `cnt_clr_i` was high (the clear wins over counting).
- R10: `host_gnt_o` is 1 only in a cycle where both `host_req_i` and `pipe_idle_i` are 1 and no timeout stands.
- R11: After `TMO_CYC` (default 256) consecutive edges with `host_req_i` 1 and `pipe_idle_i` 0, `host_tmo_o` becomes 1 and the grant stays 0 until `host_req_i` drops, which clears the flag on the next edge.
- R12: After reset `halt_o`, `cause_o`, `cycle_cnt_o`, `host_gnt_o` and `host_tmo_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swbp_a_i | input | 1 | First breakpoint opcode decoded |
| swbp_b_i | input | 1 | Second breakpoint opcode decoded |
| pf_addr_i | input | 22 | Program fetch address |
| pf_vld_i | input | 1 | Program fetch valid |
| da_addr_i | input | 32 | Data access address |
| da_vld_i | input | 1 | Data access valid |
| pw_en_i | input | 1 | Program watch enable |
| pw_addr_i | input | 22 | Program watch address |
| dw_en_i | input | 1 | Data watch enable |
| dw_addr_i | input | 32 | Data watch address |
| rt_mode_i | input | 1 | 1 selects real-time mode, 0 stop mode |
| crit_irq_i | input | 1 | Critical interrupt being serviced |
| run_cmd_i | input | 1 | Host resume command |
| cnt_clr_i | input | 1 | Host clear of the cycle counter |
| host_req_i | input | 1 | Host memory access request |
| pipe_idle_i | input | 1 | Pipeline leaves the buses unused this cycle |
| halt_o | output | 1 | Debug halt state |
| cause_o | output | 3 | Reason for the last break, 0 none |
| cycle_cnt_o | output | 32 | Benchmark cycle counter |
| host_gnt_o | output | 1 | Host owns the buses this cycle |
| host_tmo_o | output | 1 | Host request abandoned |

## Verification
The checker watches on every cycle that a grant never appears outside an idle requested cycle or under a timeout, that the counter steps by one while running and holds while halted, that a halted core keeps its cause until resumed, that resume clears the cause in one edge, and that a deferred real-time break never halts early. Which source wins among simultaneous events, that a mismatched or disabled watch stays silent, the exact edge on which the timeout fires, and the cause carried across a deferral are shown only by the bench's vector table and directed scenarios.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_SWBP_A = 3'd1,
    CAUSE_SWBP_B = 3'd2,
    CAUSE_PWATCH = 3'd3,
    CAUSE_DWATCH = 3'd4
  } cause_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } run_st_e;
endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic          bus_vld,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] watch_addr,
  output logic          hit
);
  always_comb begin
    hit = en && bus_vld && (bus_addr == watch_addr);
  end
endmodule

// File: rtl/dbg_evt_pri.sv
module dbg_evt_pri
  import dbg_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] src,
  output logic            any,
  output cause_e          cause
);
  // lowest index wins; code = index + 1
  always_comb begin
    any   = |src;
    cause = CAUSE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src[i]) cause = cause_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
  import dbg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_any,
  input  cause_e ev_cause,
  input  logic   rt_mode,
  input  logic   crit_irq,
  input  logic   run_cmd,
  output logic   halt,
  output cause_e cause,
  output logic   pend
);
  run_st_e st_q, st_d;
  cause_e  cause_q, cause_d;
  logic    pend_q, pend_d;
  cause_e  pcause_q, pcause_d;
  logic    blocked;

  always_comb begin
    blocked  = rt_mode && crit_irq;
    st_d     = st_q;
    cause_d  = cause_q;
    pend_d   = pend_q;
    pcause_d = pcause_q;
    unique case (st_q)
      ST_RUN: begin
        if ((ev_any || pend_q) && !blocked) begin
          st_d    = ST_HALT;
          cause_d = pend_q ? pcause_q : ev_cause;
          pend_d  = 1'b0;
          pcause_d = CAUSE_NONE;
        end else if (ev_any && !pend_q) begin
          pend_d   = 1'b1;
          pcause_d = ev_cause;
        end
      end
      ST_HALT: begin
        if (run_cmd) begin
          st_d    = ST_RUN;
          cause_d = CAUSE_NONE;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      cause_q  <= CAUSE_NONE;
      pend_q   <= 1'b0;
      pcause_q <= CAUSE_NONE;
    end else begin
      st_q     <= st_d;
      cause_q  <= cause_d;
      pend_q   <= pend_d;
      pcause_q <= pcause_d;
    end
  end

  assign halt  = (st_q == ST_HALT);
  assign cause = cause_q;
  assign pend  = pend_q;
endmodule

// File: rtl/dbg_cycle_ctr.sv
module dbg_cycle_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cnt_en,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ld_en;

  always_comb begin
    ld_en = clr || cnt_en;
    cnt_d = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ld_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dbg_host_arb.sv
module dbg_host_arb #(
  parameter int TMO_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic idle,
  output logic gnt,
  output logic tmo
);
  localparam int WW = $clog2(TMO_CYC + 1);

  logic [WW-1:0] wait_q, wait_d;
  logic          tmo_q, tmo_d;
  logic          starve;

  always_comb begin
    starve = req && !idle && !tmo_q;
    wait_d = wait_q;
    tmo_d  = tmo_q;
    if (!req) begin
      wait_d = '0;
      tmo_d  = 1'b0;
    end else if (idle) begin
      wait_d = '0;
    end else if (starve) begin
      if (wait_q == WW'(TMO_CYC - 1)) begin
        tmo_d  = 1'b1;
        wait_d = '0;
      end else begin
        wait_d = wait_q + WW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      tmo_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      tmo_q  <= tmo_d;
    end
  end

  assign gnt = req && idle && !tmo_q;
  assign tmo = tmo_q;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_pkg::*;
#(
  parameter int PAW     = 22,
  parameter int DAW     = 32,
  parameter int CW      = 32,
  parameter int TMO_CYC = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           swbp_a_i,
  input  logic           swbp_b_i,
  input  logic [PAW-1:0] pf_addr_i,
  input  logic           pf_vld_i,
  input  logic [DAW-1:0] da_addr_i,
  input  logic           da_vld_i,
  input  logic           pw_en_i,
  input  logic [PAW-1:0] pw_addr_i,
  input  logic           dw_en_i,
  input  logic [DAW-1:0] dw_addr_i,
  input  logic           rt_mode_i,
  input  logic           crit_irq_i,
  input  logic           run_cmd_i,
  input  logic           cnt_clr_i,
  input  logic           host_req_i,
  input  logic           pipe_idle_i,
  output logic           halt_o,
  output logic [2:0]     cause_o,
  output logic [CW-1:0]  cycle_cnt_o,
  output logic           host_gnt_o,
  output logic           host_tmo_o
);
  localparam int NSRC = 4;

  logic            rst_sync_n;
  logic            p_hit, d_hit;
  logic [NSRC-1:0] ev_src;
  logic            ev_any;
  cause_e          ev_cause;
  cause_e          cause_q;
  logic            brk_pend;

  dbg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dbg_addr_cmp #(.AW(PAW)) u_pcmp (
    .en(pw_en_i), .bus_vld(pf_vld_i), .bus_addr(pf_addr_i),
    .watch_addr(pw_addr_i), .hit(p_hit)
  );

  dbg_addr_cmp #(.AW(DAW)) u_dcmp (
    .en(dw_en_i), .bus_vld(da_vld_i), .bus_addr(da_addr_i),
    .watch_addr(dw_addr_i), .hit(d_hit)
  );

  assign ev_src = {d_hit, p_hit, swbp_b_i, swbp_a_i};

  dbg_evt_pri #(.NSRC(NSRC)) u_pri (
    .src(ev_src), .any(ev_any), .cause(ev_cause)
  );

  dbg_run_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .ev_any(ev_any), .ev_cause(ev_cause),
    .rt_mode(rt_mode_i), .crit_irq(crit_irq_i), .run_cmd(run_cmd_i),
    .halt(halt_o), .cause(cause_q), .pend(brk_pend)
  );

  assign cause_o = cause_q;

  dbg_cycle_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr_i), .cnt_en(!halt_o),
    .cnt(cycle_cnt_o)
  );

  dbg_host_arb #(.TMO_CYC(TMO_CYC)) u_arb (
    .clk(clk), .rst_n(rst_sync_n), .req(host_req_i), .idle(pipe_idle_i),
    .gnt(host_gnt_o), .tmo(host_tmo_o)
  );
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          swbp_a_i,
  input logic          rt_mode_i,
  input logic          crit_irq_i,
  input logic          run_cmd_i,
  input logic          cnt_clr_i,
  input logic          host_req_i,
  input logic          pipe_idle_i,
  input logic          halt_o,
  input logic [2:0]    cause_o,
  input logic [CW-1:0] cycle_cnt_o,
  input logic          host_gnt_o,
  input logic          host_tmo_o,
  input logic          brk_pend
);
  // R1
  a_r1_swbp_a_halts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!halt_o && !brk_pend && swbp_a_i && !(rt_mode_i && crit_irq_i))
    |=> (halt_o && cause_o == 3'd1));

  // R6
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_o && !run_cmd_i) |=> (halt_o && $stable(cause_o)));

  // R7
  a_r7_run_resumes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_o && run_cmd_i) |=> (!halt_o && cause_o == 3'd0));

  // R8
  a_r8_rt_defer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!halt_o && rt_mode_i && crit_irq_i) |=> !halt_o);

  // R9
  a_r9_cnt_freeze: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_o && !cnt_clr_i) |=> $stable(cycle_cnt_o));

  a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!halt_o && !cnt_clr_i) |=> (cycle_cnt_o == $past(cycle_cnt_o) + CW'(1)));

  // R10
  a_r10_gnt_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_gnt_o |-> (host_req_i && pipe_idle_i));

  // R11
  a_r11_tmo_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_tmo_o |-> !host_gnt_o);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .swbp_a_i(swbp_a_i),
  .rt_mode_i(rt_mode_i), .crit_irq_i(crit_irq_i), .run_cmd_i(run_cmd_i),
  .cnt_clr_i(cnt_clr_i), .host_req_i(host_req_i), .pipe_idle_i(pipe_idle_i),
  .halt_o(halt_o), .cause_o(cause_o), .cycle_cnt_o(cycle_cnt_o),
  .host_gnt_o(host_gnt_o), .host_tmo_o(host_tmo_o), .brk_pend(brk_pend)
);

// File: tb/dbg_halt_ctrl_tb_top.sv
module dbg_halt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO       = 256;
  localparam int NVEC      = 20;
  localparam logic [21:0] PW = 22'h000123;
  localparam logic [31:0] DW = 32'h00000456;

  typedef struct packed {
    logic        a, b, pv;
    logic [21:0] pa;
    logic        dv;
    logic [31:0] da;
    logic        rt, crit, run, x_halt;
    logic [2:0]  x_cause;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}, // R12 idle, run ignored
    '{1'b1,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b0, 1'b1,3'd1}, // R1
    '{1'b0,1'b1,1'b1,PW,       1'b0,32'h0,  1'b0,1'b0,1'b0, 1'b1,3'd1}, // R6
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}, // R7
    '{1'b0,1'b1,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b0, 1'b1,3'd2}, // R1
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}, // R7
    '{1'b0,1'b0,1'b1,PW,       1'b0,32'h0,  1'b0,1'b0,1'b0, 1'b1,3'd3}, // R2
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}, // R7
    '{1'b0,1'b0,1'b0,22'h0,    1'b1,DW,     1'b0,1'b0,1'b0, 1'b1,3'd4}, // R3
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}, // R7
    '{1'b0,1'b0,1'b1,22'h124,  1'b1,32'h457,1'b0,1'b0,1'b0, 1'b0,3'd0}, // R5 mismatch
    '{1'b0,1'b0,1'b0,PW,       1'b0,DW,     1'b0,1'b0,1'b0, 1'b0,3'd0}, // R5 invalid
    '{1'b1,1'b1,1'b1,PW,       1'b1,DW,     1'b0,1'b0,1'b0, 1'b1,3'd1}, // R4
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}, // R7
    '{1'b0,1'b0,1'b1,PW,       1'b1,DW,     1'b0,1'b0,1'b0, 1'b1,3'd3}, // R4
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}, // R7
    '{1'b0,1'b0,1'b0,22'h0,    1'b1,DW,     1'b1,1'b1,1'b0, 1'b0,3'd0}, // R8 deferred
    '{1'b0,1'b1,1'b0,22'h0,    1'b0,32'h0,  1'b1,1'b1,1'b0, 1'b0,3'd0}, // R8 still held
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b1,1'b0,1'b0, 1'b1,3'd4}, // R8 released
    '{1'b0,1'b0,1'b0,22'h0,    1'b0,32'h0,  1'b0,1'b0,1'b1, 1'b0,3'd0}  // R7
  };

  logic        clk, rst_n;
  logic        swbp_a_i, swbp_b_i, pf_vld_i, da_vld_i;
  logic [21:0] pf_addr_i, pw_addr_i;
  logic [31:0] da_addr_i, dw_addr_i;
  logic        pw_en_i, dw_en_i, rt_mode_i, crit_irq_i, run_cmd_i, cnt_clr_i;
  logic        host_req_i, pipe_idle_i;
  logic        halt_o, host_gnt_o, host_tmo_o;
  logic [2:0]  cause_o;
  logic [31:0] cycle_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  dbg_halt_ctrl #(.TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .swbp_a_i(swbp_a_i), .swbp_b_i(swbp_b_i),
    .pf_addr_i(pf_addr_i), .pf_vld_i(pf_vld_i), .da_addr_i(da_addr_i),
    .da_vld_i(da_vld_i), .pw_en_i(pw_en_i), .pw_addr_i(pw_addr_i),
    .dw_en_i(dw_en_i), .dw_addr_i(dw_addr_i), .rt_mode_i(rt_mode_i),
    .crit_irq_i(crit_irq_i), .run_cmd_i(run_cmd_i), .cnt_clr_i(cnt_clr_i),
    .host_req_i(host_req_i), .pipe_idle_i(pipe_idle_i), .halt_o(halt_o),
    .cause_o(cause_o), .cycle_cnt_o(cycle_cnt_o), .host_gnt_o(host_gnt_o),
    .host_tmo_o(host_tmo_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    swbp_a_i = 0; swbp_b_i = 0; pf_vld_i = 0; da_vld_i = 0;
    pf_addr_i = '0; da_addr_i = '0; rt_mode_i = 0; crit_irq_i = 0;
    run_cmd_i = 0; cnt_clr_i = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    quiet();
    pw_en_i = 1; dw_en_i = 1; pw_addr_i = PW; dw_addr_i = DW;
    host_req_i = 0; pipe_idle_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 halt", 32'(halt_o), 0);
    check("R12 cause", 32'(cause_o), 0);
    check("R12 gnt", 32'(host_gnt_o), 0);
    check("R12 tmo", 32'(host_tmo_o), 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      swbp_a_i = VECS[i].a; swbp_b_i = VECS[i].b;
      pf_vld_i = VECS[i].pv; pf_addr_i = VECS[i].pa;
      da_vld_i = VECS[i].dv; da_addr_i = VECS[i].da;
      rt_mode_i = VECS[i].rt; crit_irq_i = VECS[i].crit;
      run_cmd_i = VECS[i].run;
      @(negedge clk);
      check($sformatf("R1-table vec%0d halt", i), 32'(halt_o), 32'(VECS[i].x_halt));
      check($sformatf("R4-table vec%0d cause", i), 32'(cause_o), 32'(VECS[i].x_cause));
    end
    quiet();

    // R5 disabled watches
    pw_en_i = 0; dw_en_i = 0;
    pf_vld_i = 1; pf_addr_i = PW; da_vld_i = 1; da_addr_i = DW;
    @(negedge clk);
    check("R5 disabled halt", 32'(halt_o), 0);
    quiet(); pw_en_i = 1; dw_en_i = 1;

    // R8 stop mode ignores interrupt input
    crit_irq_i = 1; swbp_b_i = 1;
    @(negedge clk);
    check("R8 stop-mode halt", 32'(halt_o), 1);
    check("R8 stop-mode cause", 32'(cause_o), 2);
    quiet(); run_cmd_i = 1;
    @(negedge clk);
    quiet();

    // R9 counter clear, count, freeze
    cnt_clr_i = 1;
    @(negedge clk);
    check("R9 clear", cycle_cnt_o, 0);
    cnt_clr_i = 0;
    repeat (10) @(negedge clk);
    check("R9 count", cycle_cnt_o, 10);
    swbp_a_i = 1;
    @(negedge clk);
    swbp_a_i = 0;
    repeat (5) @(negedge clk);
    check("R9 freeze", cycle_cnt_o, 11);
    cnt_clr_i = 1;
    @(negedge clk);
    cnt_clr_i = 0;
    check("R9 clear halted", cycle_cnt_o, 0);
    run_cmd_i = 1;
    @(negedge clk);
    run_cmd_i = 0;

    // R10 grant only in idle cycles
    host_req_i = 1; pipe_idle_i = 1;
    #1 check("R10 grant idle", 32'(host_gnt_o), 1);
    pipe_idle_i = 0;
    #1 check("R10 busy no grant", 32'(host_gnt_o), 0);
    host_req_i = 0; pipe_idle_i = 1;
    #1 check("R10 no req no grant", 32'(host_gnt_o), 0);
    @(negedge clk);

    // R11 timeout
    host_req_i = 1; pipe_idle_i = 0;
    repeat (TMO - 1) @(negedge clk);
    check("R11 before limit", 32'(host_tmo_o), 0);
    @(negedge clk);
    check("R11 at limit", 32'(host_tmo_o), 1);
    pipe_idle_i = 1;
    #1 check("R11 aborted grant", 32'(host_gnt_o), 0);
    host_req_i = 0;
    @(negedge clk);
    check("R11 flag cleared", 32'(host_tmo_o), 0);
    host_req_i = 1;
    #1 check("R11 grant after clear", 32'(host_gnt_o), 1);
    host_req_i = 0;
    @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule